// File: doc/BRIEF.md
# System Error Reporter

This block gathers error events inside a bus bridge system controller and signals them on a shared, active-low system error line. Two causes can fire the line: a parity fault detected on a main-memory read, and a target abort received while the controller was acting as bus master. Parity faults seen on the peripheral bus itself are ignored by design.

The line is driven only while a pulse is in progress, and each pulse lasts one bus clock. At all other times the output enable is released, so several drivers can share the line in wired-OR fashion. Reporting is gated by an enable bit that software sets through a small command write port.

Two sticky status bits record what happened. Software reads them and clears them with a write-one-to-clear access.

Top module: `sys_err_report`

## Requirements
- R1: A strobe on `bus_perr` never causes a pulse and never changes a status bit.
- R2: With the enable bit set, a `mem_perr` strobe sampled at a clock edge drives the line low (`err_n`=0, `err_oe`=1) for the cycle that follows that edge.
- R3: With the enable bit set, a `tgt_abort` strobe causes the same one-cycle pulse as R2.
- R4: With the enable bit clear, neither cause produces a pulse or sets either status bit.
- R5: A pulse lasts exactly one cycle. In the next cycle the line is released unless a new enabled cause was sampled at the edge that ends the pulse. Causes that arrive together in one cycle produce a single pulse cycle.
- R6: Status bit 0 (memory parity) is set on the same edge that starts a pulse caused by an enabled `mem_perr`.
- R7: Status bit 1 (error signalled) is set on every edge that starts a pulse.
- R8: Both status bits are sticky. A write with `sts_clr` high clears each bit whose `sts_wdata` bit is 1. If a set and a clear of the same bit happen in one cycle, the set wins.
- R9: While released, the line shows `err_oe`=0 and `err_n`=1. The bench never observes `err_oe`=1 together with `err_n`=1.
- R10: After reset the enable bit, both status bits and `err_oe` are 0, and `err_n` is 1.
- R11: A `cmd_wr` access loads `cmd_en` into the enable bit. The new value gates causes from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_en | input | 1 | Enable value written by `cmd_wr` |
| mem_perr | input | 1 | Main-memory read parity error strobe |
| tgt_abort | input | 1 | Target abort received as master strobe |
| bus_perr | input | 1 | Peripheral-bus parity error strobe (ignored) |
| sts_clr | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 2 | Clear mask: bit 0 memory parity, bit 1 signalled |
| en_q | output | 1 | Current enable bit |
| sts_q | output | 2 | Status: bit 0 memory parity, bit 1 signalled |
| err_n | output | 1 | Active-low system error level |
| err_oe | output | 1 | Output enable for the error line |

## Verification
On every cycle, the assertions check three things. A pulse is always preceded by an enabled cause. A lone bus parity strobe never starts a pulse. A status bit never drops without a matching clear. Whether a pulse ends after exactly one cycle, and how a set and a clear collide, depend on the exact input history. Those, and the enable write latency, are shown by the bench's reference model over mixed random and directed traffic.

// File: rtl/sys_err_report.sv
module sys_err_report (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_en,
  input  logic       mem_perr,
  input  logic       tgt_abort,
  input  logic       bus_perr,
  input  logic       sts_clr,
  input  logic [1:0] sts_wdata,
  output logic       en_q,
  output logic [1:0] sts_q,
  output logic       err_n,
  output logic       err_oe
);
  logic       mem_hit, fire, pulse_q;
  logic [1:0] clr_mask, set_mask;

  // bus_perr is intentionally left unused: peripheral parity is not reported
  logic unused_ok;
  assign unused_ok = bus_perr;

  assign mem_hit  = en_q & mem_perr;
  assign fire     = en_q & (mem_perr | tgt_abort);
  assign clr_mask = sts_clr ? sts_wdata : 2'b00;
  assign set_mask = {fire, mem_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
      sts_q   <= 2'b00;
    end else begin
      if (cmd_wr) en_q <= cmd_en;
      pulse_q <= fire;
      sts_q   <= (sts_q & ~clr_mask) | set_mask;
    end
  end

  assign err_oe = pulse_q;
  assign err_n  = ~pulse_q;
endmodule

module sys_err_report_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_perr,
  input logic       tgt_abort,
  input logic       bus_perr,
  input logic       sts_clr,
  input logic [1:0] sts_wdata,
  input logic       en_q,
  input logic [1:0] sts_q,
  input logic       err_oe
);
  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_oe) |-> $past(en_q & (mem_perr | tgt_abort)));
  // R1
  bus_perr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_perr & !mem_perr & !tgt_abort) |=> !err_oe);
  // R7
  signalled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe |-> sts_q[1]);
  // R6
  mperr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & mem_perr) |=> sts_q[0]);
  // R8
  sticky0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q[0]) |-> $past(sts_clr & sts_wdata[0]));
  // R8
  sticky1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_q[1]) |-> $past(sts_clr & sts_wdata[1]));
  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q & !err_oe) |=> !err_oe);
endmodule

bind sys_err_report sys_err_report_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_perr(mem_perr), .tgt_abort(tgt_abort),
  .bus_perr(bus_perr), .sts_clr(sts_clr), .sts_wdata(sts_wdata),
  .en_q(en_q), .sts_q(sts_q), .err_oe(err_oe));

// File: tb/sys_err_report_bench.sv
module sys_err_report_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_en = 0, mem_perr = 0, tgt_abort = 0, bus_perr = 0, sts_clr = 0;
  logic [1:0] sts_wdata = 0;
  logic en_q, err_n, err_oe;
  logic [1:0] sts_q;

  int total = 0, bad = 0;
  logic m_en = 0, m_pulse = 0;
  logic [1:0] m_sts = 0;

  always #2.5 clk = ~clk;

  sys_err_report u_sys_err_report (.*);

  function automatic logic [1:0] next_sts(logic [1:0] s, logic en, logic mp, logic ta,
                                          logic clr, logic [1:0] w);
    logic [1:0] k;
    k = clr ? (s & ~w) : s;
    return k | {en & (mp | ta), en & mp};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    chk(req, {en_q, sts_q, err_oe}, {m_en, m_sts, m_pulse});
    chk("R9", {err_n, err_oe}, {~m_pulse, m_pulse});
  endtask

  // drive one cycle: apply at negedge, model the edge, compare at next negedge
  task automatic step(string req, logic w, logic e, logic mp, logic ta, logic bp,
                      logic c, logic [1:0] wd);
    cmd_wr = w; cmd_en = e; mem_perr = mp; tgt_abort = ta; bus_perr = bp;
    sts_clr = c; sts_wdata = wd;
    @(posedge clk);
    m_pulse = m_en & (mp | ta);
    m_sts   = next_sts(m_sts, m_en, mp, ta, c, wd);
    if (w) m_en = e;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    // R4: disabled causes do nothing
    step("R4", 0,0, 1,1,0, 0,2'b00);
    step("R4", 0,0, 0,0,0, 0,2'b00);
    // R1: bus parity ignored while enabled
    step("R11", 1,1, 0,0,0, 0,2'b00);
    step("R1", 0,0, 0,0,1, 0,2'b00);
    step("R1", 0,0, 0,0,0, 0,2'b00);
    // R2/R6/R7 memory parity
    step("R2", 0,0, 1,0,0, 0,2'b00);
    step("R5", 0,0, 0,0,0, 0,2'b00);
    // R8 clear, then R3 abort only sets bit1
    step("R8", 0,0, 0,0,0, 1,2'b11);
    step("R3", 0,0, 0,1,0, 0,2'b00);
    // R5 simultaneous causes and back-to-back
    step("R5", 0,0, 1,1,1, 0,2'b00);
    step("R5", 0,0, 1,0,0, 0,2'b00);
    step("R5", 0,0, 0,0,0, 0,2'b00);
    // R8 set wins over clear in same cycle
    step("R8", 0,0, 1,0,0, 1,2'b11);
    step("R8", 0,0, 0,0,0, 1,2'b01);
    // R11 disable takes effect next cycle
    step("R11", 1,0, 1,0,0, 0,2'b00);
    step("R11", 0,0, 1,1,0, 0,2'b00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step("R2", ($urandom%8)==0, $urandom%4 != 0, ($urandom%5)==0, ($urandom%6)==0,
           $urandom%2, ($urandom%4)==0, 2'($urandom));
    end
    // R10 reset mid-run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    m_en = 0; m_sts = 0; m_pulse = 0;
    compare("R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule